// File: doc/BRIEF.md
# Buffered Page Program Controller for Serial NOR Flash

This block writes one page-program frame to a serial NOR flash over a single-lane SPI bus. Software loads an opcode, a 3- or 4-byte flash address and the data through a small word-addressed register bus, then sets a start bit. The controller shifts the opcode, the address (most significant byte first) and the data out in SPI mode 0 with no dummy cycles. It clears the start bit by itself when chip select returns high.

The data comes from one of two sources. In single-byte mode the frame carries one byte taken from a data register. In burst mode a 128-byte staging buffer is filled by 32 consecutive 32-bit writes to one port, with the lowest byte lane sent first. Burst mode is requested through an enable bit whose readback shows the acknowledged state one clock later. Software polls that bit before loading data. The flash's write-enable command and its status polling are left to software.

Register word indices on `bus_addr`: 0 command, 1 opcode, 2 address low byte, 3 address middle byte, 4 address high byte, 5 address top byte, 6 bus configuration, 7 buffer configuration, 8 single data byte, 9 burst data port.

Top module: `nor_pp_ctrl`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and command bit 4 (index 0) and buffer-configuration bit 0 (index 7) both read 0.
- R2: Writing bit 0 of index 7 requests burst mode. The readback of that bit shows the request from the first clock edge after the write, and still shows the old value between the write edge and that edge.
- R3: With burst mode off, a frame is the opcode byte (index 1 bits 7:0), then the address bytes high (index 4), middle (index 3) and low (index 2), then one data byte from index 8 bits 7:0. Each byte is sent MSB first, and spi_mosi is valid at every rising spi_sck while spi_cs_n is low.
- R4: When bit 4 of index 6 is set, the top address byte (index 5) is sent before the high byte. When that bit is clear, index 5 is not sent.
- R5: With burst mode acknowledged and 32 words loaded, the frame carries 128 data bytes. Word k's bits 7:0 are data byte 4k and its bits 31:24 are data byte 4k+3.
- R6: Writing index 0 with bit 4 set starts a frame. Bit 4 reads 1 until the edge 2*8*N clocks after the start edge, where N is the frame length in bytes, and reads 0 from that edge on. spi_sck runs at half the clock rate.
- R7: A start issued while burst mode is acknowledged and fewer than 32 words are loaded produces no frame: bit 4 reads 0 right after the write edge and spi_cs_n stays high.
- R8: Burst-port writes beyond the 32nd are dropped and leave the loaded data unchanged.
- R9: The buffer fill count returns to zero when burst mode goes from off to on and when a burst frame completes.
- R10: Register writes issued while a frame is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, taken when bus_sel is high |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI serial data to the flash |

## Verification
The enable acknowledge appears one edge after its write, so the bench reads it once before that edge and once after it. A start that is accepted keeps bit 4 at 1 for exactly 16*N clocks. The bench counts 16*N-1 falling edges after the write edge, expects 1, then expects 0 one clock later. A start that is ignored must read 0 on the very next sample. Frame contents are collected on every rising spi_sck while chip select is low, and are compared byte by byte against a stream the bench builds from the register values it wrote.

// File: rtl/nor_pp_pkg.sv
package nor_pp_pkg;
  typedef enum logic [3:0] {
    REG_CMD   = 4'd0,
    REG_OPC   = 4'd1,
    REG_ALO   = 4'd2,
    REG_AMID  = 4'd3,
    REG_AHI   = 4'd4,
    REG_ATOP  = 4'd5,
    REG_BUS   = 4'd6,
    REG_CFG   = 4'd7,
    REG_WDAT  = 4'd8,
    REG_BURST = 4'd9
  } reg_idx_e;

  localparam int START_BIT     = 4;
  localparam int WIDE_ADDR_BIT = 4;
  localparam int BUF_EN_BIT    = 0;
endpackage

// File: rtl/nor_pp_regs.sv
module nor_pp_regs
  import nor_pp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic        busy,
  output logic [31:0] rdata,
  output logic [7:0]  opcode,
  output logic [31:0] addr_word,
  output logic        wide_addr,
  output logic        buf_ack,
  output logic [7:0]  single_byte,
  output logic        start_req,
  output logic        word_wr,
  output logic        buf_rise
);
  logic            wr_ok;
  logic [7:0]      opc_q, opc_d;
  logic [3:0][7:0] adr_q, adr_d;
  logic            wide_q, wide_d;
  logic            req_q, req_d;
  logic            ack_q, ack_d;
  logic [7:0]      wdat_q, wdat_d;
  reg_idx_e        idx;

  assign idx   = reg_idx_e'(bus_addr);
  assign wr_ok = bus_sel & bus_we & ~busy;

  always_comb begin
    opc_d  = opc_q;
    adr_d  = adr_q;
    wide_d = wide_q;
    req_d  = req_q;
    wdat_d = wdat_q;
    ack_d  = req_q;
    if (wr_ok) begin
      case (idx)
        REG_OPC:  opc_d    = bus_wdata[7:0];
        REG_ALO:  adr_d[0] = bus_wdata[7:0];
        REG_AMID: adr_d[1] = bus_wdata[7:0];
        REG_AHI:  adr_d[2] = bus_wdata[7:0];
        REG_ATOP: adr_d[3] = bus_wdata[7:0];
        REG_BUS:  wide_d   = bus_wdata[WIDE_ADDR_BIT];
        REG_CFG:  req_d    = bus_wdata[BUF_EN_BIT];
        REG_WDAT: wdat_d   = bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opc_q  <= '0;
      adr_q  <= '0;
      wide_q <= 1'b0;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
      wdat_q <= '0;
    end else begin
      opc_q  <= opc_d;
      adr_q  <= adr_d;
      wide_q <= wide_d;
      req_q  <= req_d;
      ack_q  <= ack_d;
      wdat_q <= wdat_d;
    end
  end

  assign start_req   = wr_ok && (idx == REG_CMD) && bus_wdata[START_BIT];
  assign word_wr     = wr_ok && (idx == REG_BURST);
  assign buf_rise    = wr_ok && (idx == REG_CFG) && bus_wdata[BUF_EN_BIT] && !req_q;
  assign opcode      = opc_q;
  assign addr_word   = adr_q;
  assign wide_addr   = wide_q;
  assign buf_ack     = ack_q;
  assign single_byte = wdat_q;

  always_comb begin
    rdata = '0;
    case (idx)
      REG_CMD:  rdata = 32'(busy) << START_BIT;
      REG_OPC:  rdata = {24'h0, opc_q};
      REG_ALO:  rdata = {24'h0, adr_q[0]};
      REG_AMID: rdata = {24'h0, adr_q[1]};
      REG_AHI:  rdata = {24'h0, adr_q[2]};
      REG_ATOP: rdata = {24'h0, adr_q[3]};
      REG_BUS:  rdata = 32'(wide_q) << WIDE_ADDR_BIT;
      REG_CFG:  rdata = 32'(ack_q) << BUF_EN_BIT;
      REG_WDAT: rdata = {24'h0, wdat_q};
      default:  rdata = '0;
    endcase
  end

  // R2: acknowledge never rises without a request standing the cycle before
  assert_ack_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(req_q));

  // R10: a held register cannot change while a frame is running
  assert_locked_opcode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(opc_q));
endmodule

// File: rtl/nor_pp_wbuf.sv
module nor_pp_wbuf #(
  parameter int BUF_BYTES = 128,
  parameter int WORD_W    = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_wr,
  input  logic [WORD_W-1:0]            word_data,
  input  logic                         clear,
  input  logic [$clog2(BUF_BYTES)-1:0] rd_idx,
  output logic [7:0]                   rd_byte,
  output logic                         full
);
  localparam int LANES  = WORD_W / 8;
  localparam int WORDS  = BUF_BYTES / LANES;
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int BSEL_W = $clog2(LANES);
  localparam int WIDX_W = IDX_W - BSEL_W;
  localparam int PTR_W  = $clog2(WORDS + 1);

  logic [PTR_W-1:0]  fill_q, fill_d;
  logic              accept;
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] rd_word;

  assign full   = (fill_q == PTR_W'(WORDS));
  assign accept = word_wr && !full;

  always_comb begin
    fill_d = fill_q;
    if (clear)       fill_d = '0;
    else if (accept) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = accept && (fill_q[WIDX_W-1:0] == WIDX_W'(w));
    always_ff @(posedge clk) begin
      if (hit) mem[w] <= word_data;
    end
  end

  assign rd_word = mem[rd_idx[IDX_W-1:BSEL_W]];
  assign rd_byte = rd_word[{rd_idx[BSEL_W-1:0], 3'b000} +: 8];

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= PTR_W'(WORDS));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && word_wr && !clear) |=> full);

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (fill_q == '0));
endmodule

// File: rtl/nor_pp_shifter.sv
module nor_pp_shifter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] total_bytes,
  input  logic [7:0]       cur_byte,
  output logic [CNT_W-1:0] byte_idx,
  output logic             busy,
  output logic             done,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi
);
  logic             act_q, act_d;
  logic             ph_q, ph_d;
  logic [2:0]       bit_q, bit_d;
  logic [CNT_W-1:0] byte_q, byte_d;
  logic [CNT_W-1:0] tot_q, tot_d;
  logic             last_bit;

  assign last_bit = (bit_q == 3'd7) && (byte_q == tot_q - 1'b1);
  assign done     = act_q && ph_q && last_bit;

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    tot_d  = tot_q;
    if (!act_q) begin
      if (start) begin
        act_d  = 1'b1;
        ph_d   = 1'b0;
        bit_d  = '0;
        byte_d = '0;
        tot_d  = total_bytes;
      end
    end else if (!ph_q) begin
      ph_d = 1'b1;
    end else begin
      ph_d = 1'b0;
      if (last_bit) begin
        act_d = 1'b0;
      end else if (bit_q == 3'd7) begin
        bit_d  = '0;
        byte_d = byte_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      tot_q  <= '0;
    end else begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      tot_q  <= tot_d;
    end
  end

  assign byte_idx = byte_q;
  assign busy     = act_q;
  assign spi_cs_n = ~act_q;
  assign spi_sck  = act_q & ph_q;
  assign spi_mosi = act_q & cur_byte[3'd7 - bit_q];

  assert_byte_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (byte_q < tot_q));

  assert_sck_alternates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && $past(spi_sck)) |-> !spi_sck);
endmodule

// File: rtl/nor_pp_ctrl.sv
module nor_pp_ctrl
  import nor_pp_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int WORD_W    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int CNT_W = $clog2(BUF_BYTES + 6);

  logic [1:0]       rst_sync;
  logic             rst_ni;
  logic [7:0]       opcode, single_byte, rd_byte, cur_byte;
  logic [31:0]      addr_word;
  logic             wide_addr, buf_ack, start_req, word_wr, buf_rise;
  logic             full, busy, done, go;
  logic             burst_q, burst_d;
  logic [2:0]       n_addr;
  logic [CNT_W-1:0] total_bytes, byte_idx, lane_sel, data_off;
  logic [IDX_W-1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  nor_pp_regs u_regs (
    .clk(clk), .rst_n(rst_ni), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy), .rdata(bus_rdata),
    .opcode(opcode), .addr_word(addr_word), .wide_addr(wide_addr),
    .buf_ack(buf_ack), .single_byte(single_byte), .start_req(start_req),
    .word_wr(word_wr), .buf_rise(buf_rise)
  );

  nor_pp_wbuf #(.BUF_BYTES(BUF_BYTES), .WORD_W(WORD_W)) u_wbuf (
    .clk(clk), .rst_n(rst_ni), .word_wr(word_wr), .word_data(bus_wdata[WORD_W-1:0]),
    .clear(buf_rise | (done & burst_q)), .rd_idx(rd_idx), .rd_byte(rd_byte), .full(full)
  );

  assign go     = start_req && (!buf_ack || full);
  assign n_addr = wide_addr ? 3'd4 : 3'd3;
  assign total_bytes = CNT_W'(1) + CNT_W'(n_addr)
                     + ((buf_ack && full) ? CNT_W'(BUF_BYTES) : CNT_W'(1));

  always_comb begin
    burst_d = burst_q;
    if (go) burst_d = buf_ack && full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      burst_q <= 1'b0;
    else if (!rst_ni) burst_q <= 1'b0;
    else             burst_q <= burst_d;
  end

  assign lane_sel = CNT_W'(n_addr) - byte_idx;
  assign data_off = byte_idx - CNT_W'(n_addr) - CNT_W'(1);

  always_comb begin
    cur_byte = single_byte;
    rd_idx   = data_off[IDX_W-1:0];
    if (byte_idx == '0)
      cur_byte = opcode;
    else if (byte_idx <= CNT_W'(n_addr))
      cur_byte = addr_word[{lane_sel[1:0], 3'b000} +: 8];
    else if (burst_q)
      cur_byte = rd_byte;
  end

  nor_pp_shifter #(.CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_ni), .start(go), .total_bytes(total_bytes),
    .cur_byte(cur_byte), .byte_idx(byte_idx), .busy(busy), .done(done),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  assert_short_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_req && buf_ack && !full) |=> !busy);

  assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(busy) |-> $past(start_req));

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    spi_cs_n |-> !spi_sck);
endmodule

// File: tb/nor_pp_ctrl_test.sv
`timescale 1ns/1ps
module nor_pp_ctrl_test;
  logic        clk, rst_n, bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;

  int checks = 0, fails = 0;
  int cap_bits = 0;
  logic [7:0] cap [140];
  logic [7:0] exp_s [140];
  int n_exp;

  nor_pp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge spi_sck) begin
    if (!spi_cs_n && cap_bits < 8 * 140) begin
      cap[cap_bits / 8] = {cap[cap_bits / 8][6:0], spi_mosi};
      cap_bits = cap_bits + 1;
    end
  end

  // opcode, address, seed or single byte, flags {wide, burst}
  localparam logic [63:0] VEC [6] = '{
    {8'h02, 32'h00123456, 8'hA5, 14'h0, 1'b0, 1'b0},
    {8'h12, 32'h89ABCDEF, 8'h3C, 14'h0, 1'b1, 1'b0},
    {8'h02, 32'h00010000, 8'h11, 14'h0, 1'b0, 1'b1},
    {8'h12, 32'h7F00FF01, 8'hC8, 14'h0, 1'b1, 1'b1},
    {8'h32, 32'hA5123456, 8'h00, 14'h0, 1'b0, 1'b0},
    {8'h02, 32'h00000080, 8'h00, 14'h0, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] bb(input logic [7:0] seed, input int n);
    return 8'(seed + n * 13);
  endfunction

  task automatic load_words(input logic [7:0] seed);
    for (int k = 0; k < 32; k++)
      wr(4'd9, {bb(seed, 4*k+3), bb(seed, 4*k+2), bb(seed, 4*k+1), bb(seed, 4*k)});
  endtask

  task automatic build_exp(input logic [7:0] opc, input logic [31:0] adr, input bit wide,
                           input bit burst, input logic [7:0] sd);
    int na;
    na = wide ? 4 : 3;
    exp_s[0] = opc;
    for (int i = 0; i < na; i++) exp_s[1+i] = 8'(adr >> (8 * (na - 1 - i)));
    if (burst) begin
      for (int n = 0; n < 128; n++) exp_s[1+na+n] = bb(sd, n);
      n_exp = 1 + na + 128;
    end else begin
      exp_s[1+na] = sd;
      n_exp = 2 + na;
    end
  endtask

  task automatic check_stream(input string req);
    int bad;
    bad = -1;
    chk(cap_bits == n_exp * 8, req, "frame bit count", cap_bits, n_exp * 8);
    for (int i = 0; i < n_exp; i++)
      if (bad < 0 && cap[i] !== exp_s[i]) bad = i;
    if (bad < 0) chk(1'b1, req, "frame bytes", 0, 0);
    else         chk(1'b0, req, $sformatf("frame byte %0d", bad), cap[bad], exp_s[bad]);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd(4'd0, v);
      if (v[4] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] opc, sd;
    logic [31:0] adr;
    bit wide, burst;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
    rd(4'd0, v); chk(v == 0, "R1", "command readback", v, 0);
    rd(4'd7, v); chk(v == 0, "R1", "buffer cfg readback", v, 0);

    // R2 acknowledge timing
    wr(4'd7, 32'h1);
    rd(4'd7, v); chk(v[0] == 1'b0, "R2", "ack before next edge", v[0], 0);
    @(negedge clk);
    rd(4'd7, v); chk(v[0] == 1'b1, "R2", "ack after next edge", v[0], 1);
    wr(4'd7, 32'h0);
    @(negedge clk);
    rd(4'd7, v); chk(v[0] == 1'b0, "R2", "ack cleared", v[0], 0);

    // vector table: R3 single, R4 wide address, R5 burst, R6 timing
    for (int t = 0; t < 6; t++) begin
      {opc, adr, sd} = VEC[t][63:16];
      wide  = VEC[t][1];
      burst = VEC[t][0];
      wr(4'd1, {24'h0, opc});
      wr(4'd2, {24'h0, adr[7:0]});
      wr(4'd3, {24'h0, adr[15:8]});
      wr(4'd4, {24'h0, adr[23:16]});
      wr(4'd5, {24'h0, adr[31:24]});
      wr(4'd6, 32'(wide) << 4);
      wr(4'd7, 32'h0);
      if (burst) begin
        wr(4'd7, 32'h1);
        @(negedge clk);
        load_words(sd);
      end else begin
        wr(4'd8, {24'h0, sd});
      end
      build_exp(opc, adr, wide, burst, sd);
      cap_bits = 0;
      wr(4'd0, 32'h10);
      repeat (16 * n_exp - 1) @(negedge clk);
      rd(4'd0, v); chk(v[4] == 1'b1, "R6", "start bit last busy clock", v[4], 1);
      @(negedge clk);
      rd(4'd0, v); chk(v[4] == 1'b0, "R6", "start bit self-clear", v[4], 0);
      @(negedge clk);
      check_stream(burst ? "R5" : (wide ? "R4" : (t == 4 ? "R4" : "R3")));
    end

    // R7 and R9: burst just finished, fill is empty, start must be ignored
    cap_bits = 0;
    wr(4'd0, 32'h10);
    rd(4'd0, v); chk(v[4] == 1'b0, "R7", "short burst start ignored", v[4], 0);
    repeat (20) @(negedge clk);
    chk(cap_bits == 0 && spi_cs_n, "R9", "no frame after burst clear", cap_bits, 0);

    // R9: off-to-on enable resets the fill count
    for (int k = 0; k < 10; k++) wr(4'd9, 32'hEEEEEEEE);
    wr(4'd7, 32'h0);
    wr(4'd7, 32'h1);
    @(negedge clk);
    load_words(8'h40);
    build_exp(8'h02, 32'h80, 1'b0, 1'b1, 8'h40);
    cap_bits = 0;
    wr(4'd0, 32'h10);
    wait_idle();
    @(negedge clk);
    check_stream("R9");

    // R8: a 33rd word is dropped
    load_words(8'h90);
    wr(4'd9, 32'hDEADBEEF);
    build_exp(8'h02, 32'h80, 1'b0, 1'b1, 8'h90);
    cap_bits = 0;
    wr(4'd0, 32'h10);
    wait_idle();
    @(negedge clk);
    check_stream("R8");

    // R10: writes during a frame are ignored
    wr(4'd7, 32'h0);
    wr(4'd8, 32'h5A);
    @(negedge clk);
    build_exp(8'h02, 32'h80, 1'b0, 1'b0, 8'h5A);
    cap_bits = 0;
    wr(4'd0, 32'h10);
    wr(4'd1, 32'h55);
    wr(4'd8, 32'h66);
    wait_idle();
    @(negedge clk);
    rd(4'd1, v); chk(v == 32'h02, "R10", "opcode kept", v, 32'h02);
    rd(4'd8, v); chk(v == 32'h5A, "R10", "data byte kept", v, 32'h5A);
    check_stream("R10");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule